// File: doc/BRIEF.md
# Page Program Load Buffer

This block gathers the data bytes of a page program or page rewrite command in a serial non-volatile memory model. When a new command begins, it latches a starting column and clears its bookkeeping. Each complete byte that arrives from the serial shifter is then written into a page-sized buffer at the current column. The column pointer advances and wraps inside the page. A per-column loaded mask and a saturating byte count are kept alongside the buffer.

When chip select rises, the block decides whether the operation may go ahead. It drops the operation if the last byte was only partly shifted in, or if no byte arrived at all. Otherwise it emits a one-cycle commit pulse carrying the mode, the byte count and the computed busy duration. The array-write stage then uses the mask, and reads the buffered bytes through a registered read port. In rewrite mode only the masked columns are changed. Columns that were not loaded keep their old contents.

Top module: `page_load_buffer`

## Requirements
- R1: After synchronous reset, byte_count is 0, loaded_mask is all zeros and commit is 0.
- R2: A start pulse clears loaded_mask and byte_count in the next cycle and sets the column pointer to start_col.
- R3: While collecting, each byte_vld stores byte_data at the current column, sets that column's mask bit and advances the column by one; rd_data shows the buffer entry at rd_addr one cycle after rd_addr is applied.
- R4: After column FFh the next byte goes to column 00h of the same page.
- R5: When more than 256 bytes are loaded, each column holds the byte loaded last at that column.
- R6: byte_count counts the loaded bytes and saturates at 256.
- R7: A cs_rise while bit_phase is non-zero (partial byte) produces no commit.
- R8: A cs_rise with no byte loaded produces no commit.
- R9: A cs_rise with bit_phase 0 and at least one byte loaded raises commit for exactly one cycle, in the cycle after cs_rise is sampled. In that cycle commit_count is the byte count and busy_units is 1024 + 146 × count (units of 1/256 of 10 µs).
- R10: In rewrite mode (rewrite_mode = 1 at start) commit_rewrite is 1 with the commit, and loaded_mask has ones only at the columns that were loaded.
- R11: byte_vld outside a collecting operation, either before any start or after cs_rise ended one, changes neither byte_count nor loaded_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | New program/rewrite command, latches start_col and rewrite_mode |
| start_col | input | AW | Starting column within the page |
| rewrite_mode | input | 1 | 1 = rewrite, 0 = program |
| byte_vld | input | 1 | A complete byte has been received |
| byte_data | input | DW | Received byte |
| bit_phase | input | PHASE_W | Bits of the current byte already shifted in; 0 = byte boundary |
| cs_rise | input | 1 | Chip select rose |
| rd_addr | input | AW | Buffer read column |
| commit | output | 1 | One-cycle hand-off pulse |
| commit_rewrite | output | 1 | Mode of the committed operation |
| commit_count | output | AW+1 | Bytes committed |
| busy_units | output | BUSY_W | Busy duration of the committed operation |
| loaded_mask | output | 2**AW | Per-column loaded flags |
| byte_count | output | AW+1 | Saturating count of loaded bytes |
| rd_data | output | DW | Registered buffer read data |

## Verification
The bench targets the page wrap from a start near FFh. A design that left the page there would set mask bits in the wrong places or read back bytes at shifted columns. It loads 300 bytes to check that the last writer wins per column and that the count stops at 256; an unsaturated count would overflow and give the wrong busy time. It ends operations with a partial byte and with no bytes, where a design that commits anyway would show a stray commit pulse. It also sends bytes while idle, which a design that forgot its collecting state would count into the mask.

// File: rtl/page_load_buffer_pkg.sv
package page_load_buffer_pkg;
  typedef enum logic {
    MODE_PROGRAM = 1'b0,
    MODE_REWRITE = 1'b1
  } op_mode_e;
endpackage

// File: rtl/plb_store.sv
// Page buffer storage: one write port, one registered read port (RAM style).
module plb_store #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/plb_tracker.sv
// Column pointer, loaded mask and saturating byte count.
module plb_tracker #(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     start_col,
  input  logic              byte_vld,
  input  logic              cs_rise,
  output logic              collecting,
  output logic              wr_en,
  output logic [AW-1:0]     wr_col,
  output logic [(1<<AW)-1:0] mask,
  output logic [AW:0]       count,
  output logic [AW:0]       cnt_nxt
);
  localparam int DEPTH = 1 << AW;
  localparam int CNT_W = AW + 1;

  logic [AW-1:0] ptr;

  assign wr_en  = collecting && byte_vld && !start;
  assign wr_col = ptr;

  always_comb begin
    cnt_nxt = count;
    if (wr_en && (count != CNT_W'(DEPTH))) cnt_nxt = count + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      collecting <= 1'b0;
      ptr        <= '0;
      mask       <= '0;
      count      <= '0;
    end else if (start) begin
      collecting <= 1'b1;
      ptr        <= start_col;
      mask       <= '0;
      count      <= '0;
    end else begin
      if (wr_en) begin
        mask[ptr] <= 1'b1;
        ptr       <= ptr + AW'(1);
      end
      count <= cnt_nxt;
      if (cs_rise && collecting) collecting <= 1'b0;
    end
  end
endmodule

// File: rtl/plb_commit.sv
// Validity decision at chip-select rise and busy-time computation.
module plb_commit
  import page_load_buffer_pkg::*;
#(
  parameter int AW         = 8,
  parameter int PHASE_W    = 3,
  parameter int BASE_UNITS = 1024,
  parameter int BYTE_UNITS = 146,
  parameter int BUSY_W     = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               rewrite_mode,
  input  logic               collecting,
  input  logic               cs_rise,
  input  logic [PHASE_W-1:0] bit_phase,
  input  logic [AW:0]        cnt_nxt,
  output logic               commit,
  output logic               commit_rewrite,
  output logic [AW:0]        commit_count,
  output logic [BUSY_W-1:0]  busy_units
);
  op_mode_e    mode_q;
  logic        valid;
  logic [BUSY_W-1:0] busy_calc;

  assign valid = collecting && cs_rise && !start &&
                 (bit_phase == '0) && (cnt_nxt != '0);

  assign busy_calc = BUSY_W'(BASE_UNITS) +
                     BUSY_W'(cnt_nxt) * BUSY_W'(BYTE_UNITS);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q         <= MODE_PROGRAM;
      commit         <= 1'b0;
      commit_rewrite <= 1'b0;
      commit_count   <= '0;
      busy_units     <= '0;
    end else begin
      if (start) mode_q <= rewrite_mode ? MODE_REWRITE : MODE_PROGRAM;
      commit <= valid;
      if (valid) begin
        commit_rewrite <= (mode_q == MODE_REWRITE);
        commit_count   <= cnt_nxt;
        busy_units     <= busy_calc;
      end
    end
  end
endmodule

// File: rtl/page_load_buffer.sv
module page_load_buffer
  import page_load_buffer_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AW         = 8,
  parameter int PHASE_W    = 3,
  parameter int BASE_UNITS = 1024,
  parameter int BYTE_UNITS = 146,
  parameter int BUSY_W     = $clog2(BASE_UNITS + (1 << AW) * BYTE_UNITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [AW-1:0]       start_col,
  input  logic                rewrite_mode,
  input  logic                byte_vld,
  input  logic [DW-1:0]       byte_data,
  input  logic [PHASE_W-1:0]  bit_phase,
  input  logic                cs_rise,
  input  logic [AW-1:0]       rd_addr,
  output logic                commit,
  output logic                commit_rewrite,
  output logic [AW:0]         commit_count,
  output logic [BUSY_W-1:0]   busy_units,
  output logic [(1<<AW)-1:0]  loaded_mask,
  output logic [AW:0]         byte_count,
  output logic [DW-1:0]       rd_data
);
  logic          collecting;
  logic          wr_en;
  logic [AW-1:0] wr_col;
  logic [AW:0]   cnt_nxt;

  plb_tracker #(.AW(AW)) tracker_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_col  (start_col),
    .byte_vld   (byte_vld),
    .cs_rise    (cs_rise),
    .collecting (collecting),
    .wr_en      (wr_en),
    .wr_col     (wr_col),
    .mask       (loaded_mask),
    .count      (byte_count),
    .cnt_nxt    (cnt_nxt)
  );

  plb_store #(.DW(DW), .AW(AW)) store_i (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_col),
    .wdata (byte_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  plb_commit #(
    .AW(AW), .PHASE_W(PHASE_W), .BASE_UNITS(BASE_UNITS),
    .BYTE_UNITS(BYTE_UNITS), .BUSY_W(BUSY_W)
  ) commit_i (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .rewrite_mode   (rewrite_mode),
    .collecting     (collecting),
    .cs_rise        (cs_rise),
    .bit_phase      (bit_phase),
    .cnt_nxt        (cnt_nxt),
    .commit         (commit),
    .commit_rewrite (commit_rewrite),
    .commit_count   (commit_count),
    .busy_units     (busy_units)
  );
endmodule

// File: rtl/page_load_buffer_chk.sv
module page_load_buffer_chk #(
  parameter int AW      = 8,
  parameter int PHASE_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               byte_vld,
  input logic               cs_rise,
  input logic [PHASE_W-1:0] bit_phase,
  input logic               collecting,
  input logic               commit,
  input logic [AW:0]        commit_count,
  input logic [(1<<AW)-1:0] loaded_mask,
  input logic [AW:0]        byte_count
);
  localparam int DEPTH = 1 << AW;

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit); // R9
  AST_COMMIT_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(cs_rise)); // R9
  AST_NO_COMMIT_PARTIAL: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && bit_phase != '0) |=> !commit); // R7
  AST_NO_COMMIT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    commit |-> (commit_count != '0)); // R8
  AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    byte_count <= (AW+1)'(DEPTH)); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (byte_count == '0 && loaded_mask == '0)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (collecting && byte_vld && !start && byte_count < (AW+1)'(DEPTH))
      |=> byte_count == $past(byte_count) + (AW+1)'(1)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!collecting && !start) |=> ($stable(byte_count) && $stable(loaded_mask))); // R11
endmodule

bind page_load_buffer page_load_buffer_chk #(.AW(AW), .PHASE_W(PHASE_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .byte_vld     (byte_vld),
  .cs_rise      (cs_rise),
  .bit_phase    (bit_phase),
  .collecting   (collecting),
  .commit       (commit),
  .commit_count (commit_count),
  .loaded_mask  (loaded_mask),
  .byte_count   (byte_count)
);

// File: tb/page_load_buffer_tb_top.sv
module page_load_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  start_col = '0;
  logic        rewrite_mode = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [2:0]  bit_phase = '0;
  logic        cs_rise = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic        commit, commit_rewrite;
  logic [8:0]  commit_count, byte_count;
  logic [15:0] busy_units;
  logic [255:0] loaded_mask;
  logic [7:0]  rd_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  page_load_buffer dut_i (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .rewrite_mode(rewrite_mode), .byte_vld(byte_vld), .byte_data(byte_data),
    .bit_phase(bit_phase), .cs_rise(cs_rise), .rd_addr(rd_addr),
    .commit(commit), .commit_rewrite(commit_rewrite),
    .commit_count(commit_count), .busy_units(busy_units),
    .loaded_mask(loaded_mask), .byte_count(byte_count), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // fields: [31] rewrite, [30:23] column, [22:12] byte count, [11:9] phase, [8] commit expected
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 8'h00, 11'd1,   3'd0, 1'b1, 8'h00},
    {1'b1, 8'hF0, 11'd32,  3'd0, 1'b1, 8'h00},
    {1'b0, 8'h10, 11'd300, 3'd0, 1'b1, 8'h00},
    {1'b1, 8'h80, 11'd5,   3'd3, 1'b0, 8'h00},
    {1'b0, 8'h05, 11'd0,   3'd0, 1'b0, 8'h00},
    {1'b0, 8'hFF, 11'd256, 3'd0, 1'b1, 8'h00}
  };

  logic [7:0]   exp_mem [256];
  logic [255:0] exp_mask;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(byte_count == 0, "R1 count", 64'(byte_count), 0);
    chk(loaded_mask == '0, "R1 mask", 64'(loaded_mask[63:0]), 0);
    chk(commit == 1'b0, "R1 commit", 64'(commit), 0);

    // R11: byte before any start is ignored
    byte_vld = 1'b1; byte_data = 8'hA5;
    @(negedge clk);
    byte_vld = 1'b0;
    @(negedge clk);
    chk(byte_count == 0 && loaded_mask == '0, "R11 idle byte", 64'(byte_count), 0);

    for (int v = 0; v < NV; v++) begin
      automatic logic       rw  = VEC[v][31];
      automatic logic [7:0] col = VEC[v][30:23];
      automatic int         n   = int'(VEC[v][22:12]);
      automatic logic [2:0] ph  = VEC[v][11:9];
      automatic logic       ec  = VEC[v][8];
      automatic int         ecnt = (n > 256) ? 256 : n;
      automatic int         bad = 0;
      automatic string      creq = (ph != 0) ? "R7" : ((n == 0) ? "R8" : "R9");
      start = 1'b1; start_col = col; rewrite_mode = rw;
      @(negedge clk);
      start = 1'b0;
      exp_mask = '0;
      for (int i = 0; i < n; i++) begin
        automatic logic [7:0] c = col + 8'(i);
        automatic logic [7:0] d = 8'(i * 13 + v * 29 + 7);
        byte_vld = 1'b1; byte_data = d;
        exp_mem[c] = d; exp_mask[c] = 1'b1;
        @(negedge clk);
      end
      byte_vld = 1'b0;
      cs_rise = 1'b1; bit_phase = ph;
      @(negedge clk);
      cs_rise = 1'b0; bit_phase = '0;
      chk(commit == ec, creq, 64'(commit), 64'(ec));
      if (ec) begin
        chk(commit_count == 9'(ecnt), "R9 commit_count", 64'(commit_count), 64'(ecnt));
        chk(busy_units == 16'(1024 + ecnt * 146), "R9 busy", 64'(busy_units),
            64'(1024 + ecnt * 146));
        chk(commit_rewrite == rw, "R10 mode", 64'(commit_rewrite), 64'(rw));
      end
      @(negedge clk);
      chk(commit == 1'b0, "R9 pulse width", 64'(commit), 0);
      chk(byte_count == 9'(ecnt), "R6 count", 64'(byte_count), 64'(ecnt));
      chk(loaded_mask == exp_mask, rw ? "R10 mask" : "R4 mask",
          64'(loaded_mask[255:192]), 64'(exp_mask[255:192]));
      for (int c = 0; c < 256; c++) begin
        rd_addr = 8'(c);
        @(negedge clk);
        if (exp_mask[c] && rd_data != exp_mem[c]) bad++;
      end
      chk(bad == 0, (n > 256) ? "R5 contents" : "R3 contents", 64'(bad), 0);
    end

    // R11: byte after the operation ended is ignored
    byte_vld = 1'b1; byte_data = 8'h3C;
    @(negedge clk);
    byte_vld = 1'b0;
    @(negedge clk);
    chk(byte_count == 9'd256, "R11 post byte count", 64'(byte_count), 256);
    chk(loaded_mask == {256{1'b1}}, "R11 post byte mask", 64'(loaded_mask[63:0]),
        64'hFFFF_FFFF_FFFF_FFFF);

    // R2: start clears mask and count, pointer goes to start_col
    start = 1'b1; start_col = 8'h42; rewrite_mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(byte_count == 0 && loaded_mask == '0, "R2 clear", 64'(byte_count), 0);
    byte_vld = 1'b1; byte_data = 8'h99;
    @(negedge clk);
    byte_vld = 1'b0;
    chk(loaded_mask == (256'(1) << 8'h42), "R2 pointer", 64'(loaded_mask[127:64]),
        64'(1) << 2);
    cs_rise = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0;
    chk(commit == 1'b1 && commit_count == 9'd1, "R9 single", 64'(commit_count), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule